// File: doc/BRIEF.md
# PCI Target Termination Controller

This block is the target-side handshake engine of a PCI device. It watches the master's cycle-framing and master-ready lines, claims an access that the address decoder has flagged as a hit by driving the device-select line, and then paces each data phase with the target-ready line according to a ready request from the local backend. When the backend asks to end the access, the block uses the stop line to issue one of three kinds of termination. A retry ends the access before any data has moved. A disconnect ends it with or after a transfer. A target abort reports a fatal error.

All three target lines are driven from registers, with one shared output enable. The block enforces the signalling rules itself. It holds stop until the master releases the framing line. It freezes its lines while a data phase is pending. It parks the lines deasserted for one clock after the last data phase, then releases them to high impedance. It also counts the transfers in the current access and keeps a sticky flag that records any target abort it has issued. Address decoding, configuration space and parity are handled elsewhere.

Top module: `tgt_term_ctrl`

## Requirements
- R1: While reset is held low at a rising edge, all three output enables are low, every drive value is 1 (deasserted), the abort flag is 0 and the transfer count is 0.
- R2: An address phase is an edge where `cyc_n_i` is 0 and was 1 at the previous edge, while the block is idle. If `addr_hit_i` is 1 at that edge, then after the edge `sel_n_o`=0, `rdy_n_o`=1, `end_n_o`=1 and all enables are 1. Otherwise the enables stay 0, and `addr_hit_i` has no effect at any other edge of that access.
- R3: At an edge where no data phase is pending, `rdy_n_o` becomes the inverse of `be_ready_i`. `xfer_o` is 1 whenever `mrdy_n_i` and `rdy_n_o` are both 0 during an access, whatever `end_n_o` is. `xfer_cnt_o` clears at a claim and increments at every edge where `xfer_o` is 1.
- R4: Once `rdy_n_o` or `end_n_o` is 0, the three drive values do not change until an edge with `mrdy_n_i`=0 completes the data phase, whatever the backend requests.
- R5: Once `end_n_o` is 0, it stays 0 until an edge where `cyc_n_i` is 1 and the data phase completes. Withdrawing `be_stop_i` has no effect.
- R6: Retry: `be_stop_i`=1 with `be_ready_i`=0 before any transfer drives `end_n_o`=0, `rdy_n_o`=1 and `sel_n_o`=0. The access then ends with a count of 0.
- R7: Disconnect with data: `be_stop_i`=1 with `be_ready_i`=1 drives `rdy_n_o` and `end_n_o` to 0 together, with `sel_n_o`=0. After that transfer completes with `cyc_n_i` still 0, `rdy_n_o` returns to 1 while `end_n_o` stays 0.
- R8: Target abort: `be_fatal_i`=1 takes priority over the stop and ready requests. It drives `sel_n_o`=1, `end_n_o`=0 and `rdy_n_o`=1, and no transfer occurs.
- R9: `tabort_o` rises on the edge that issues a target abort, never rises for a retry or a disconnect, and stays 1 until reset.
- R10: On the clock after the last data phase completes (`cyc_n_i`=1 with the phase completing), all three drive values are 1 with the enables still 1. On the following clock all enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_n_i | input | 1 | Master cycle-framing line, active low |
| mrdy_n_i | input | 1 | Master ready line, active low |
| addr_hit_i | input | 1 | Decoder hit for the current address phase |
| be_ready_i | input | 1 | Backend can move data in this phase |
| be_stop_i | input | 1 | Backend asks to end the access (retry or disconnect) |
| be_fatal_i | input | 1 | Backend asks for a target abort |
| sel_n_o | output | 1 | Device-select drive value, active low |
| sel_oe_o | output | 1 | Device-select output enable |
| rdy_n_o | output | 1 | Target-ready drive value, active low |
| rdy_oe_o | output | 1 | Target-ready output enable |
| end_n_o | output | 1 | Stop drive value, active low |
| end_oe_o | output | 1 | Stop output enable |
| xfer_o | output | 1 | A data word moves at the coming edge |
| xfer_cnt_o | output | CNT_W | Transfers in the current or last access |
| tabort_o | output | 1 | Sticky flag: a target abort was signalled |

## Verification
The assertions assume a well-behaved master. It lowers the framing line only from the idle state. It raises the framing line no later than the edge on which it completes the final data phase. It never drops master-ready in the middle of a pending phase. The bench's master model follows these rules. It changes its inputs only at the falling clock edge, and it raises the framing line together with master-ready on the last phase, or one clock later in the lagged variants. Backend requests are changed freely, including during frozen phases, because the block must ignore them there.

// File: rtl/tgt_term_pkg.sv
// Package: shared types for the target termination controller.
// Assumes active-low bus lines; drive values of 1 mean deasserted.
package tgt_term_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PARK = 2'd2
    } tst_e;

    typedef struct packed {
        logic sel_n;
        logic rdy_n;
        logic end_n;
        logic oe;
    } pins_t;

    localparam pins_t PINS_OFF   = '{sel_n: 1'b1, rdy_n: 1'b1, end_n: 1'b1, oe: 1'b0};
    localparam pins_t PINS_CLAIM = '{sel_n: 1'b0, rdy_n: 1'b1, end_n: 1'b1, oe: 1'b1};
    localparam pins_t PINS_PARK  = '{sel_n: 1'b1, rdy_n: 1'b1, end_n: 1'b1, oe: 1'b1};

endpackage

// File: rtl/tgt_phase_mon.sv
// Module: tgt_phase_mon
// Watches the master lines against the block's own registered drive values
// and reports address phases, data-phase completion and transfers.
// Assumes the drive values come straight from registers (no loop).
module tgt_phase_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_n,
    input  logic mrdy_n,
    input  logic idle,
    input  logic in_data,
    input  logic rdy_n,
    input  logic end_n,
    output logic addr_phase,
    output logic phase_done,
    output logic last_done,
    output logic xfer
);

    logic cyc_q;

    // Remember the framing line from the previous edge to spot its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= 1'b1;
        else        cyc_q <= cyc_n;
    end

    // Decode phase events from the current line levels.
    always_comb begin
        addr_phase = idle & ~cyc_n & cyc_q;
        phase_done = in_data & ~mrdy_n & (~rdy_n | ~end_n);
        last_done  = phase_done & cyc_n;
        xfer       = in_data & ~mrdy_n & ~rdy_n;
    end

endmodule

// File: rtl/tgt_xfer_count.sv
// Module: tgt_xfer_count
// Counts transfers within one access; cleared when a new access is claimed.
// Assumes clear and increment never coincide (claim happens only when idle).
module tgt_xfer_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Clear on claim, step on every transfer edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (inc)   count <= count + ONE;
    end

endmodule

// File: rtl/tgt_abort_flag.sv
// Module: tgt_abort_flag
// Sticky record that a target abort was signalled; only reset clears it.
module tgt_abort_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic flag
);

    // Latch any abort until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
    end

endmodule

// File: rtl/tgt_term_fsm.sv
// Module: tgt_term_fsm
// Owns the registered select, ready and stop drive values and the shared
// enable. Decides claim, pacing and termination kind, holds stop, freezes
// during pending phases and runs the park-then-release sequence.
// Assumes phase events from tgt_phase_mon are based on its own outputs.
module tgt_term_fsm
    import tgt_term_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  addr_phase,
    input  logic  addr_hit,
    input  logic  phase_done,
    input  logic  last_done,
    input  logic  be_ready,
    input  logic  be_stop,
    input  logic  be_fatal,
    output pins_t pins,
    output logic  idle,
    output logic  in_data,
    output logic  claim,
    output logic  abort_issue
);

    tst_e  st, st_nxt;
    pins_t pins_nxt;
    logic  pending;

    assign idle    = (st == ST_IDLE);
    assign in_data = (st == ST_DATA);
    // A phase is pending when ready or stop is asserted and it has not completed.
    assign pending = (~pins.rdy_n | ~pins.end_n) & ~phase_done;

    // Next-state and next-drive decision.
    always_comb begin
        st_nxt      = st;
        pins_nxt    = pins;
        claim       = 1'b0;
        abort_issue = 1'b0;
        unique case (st)
            ST_IDLE: begin
                pins_nxt = PINS_OFF;
                if (addr_phase && addr_hit) begin
                    st_nxt   = ST_DATA;
                    pins_nxt = PINS_CLAIM;
                    claim    = 1'b1;
                end
            end
            ST_DATA: begin
                if (last_done) begin
                    st_nxt   = ST_PARK;
                    pins_nxt = PINS_PARK;
                end else if (!pins.end_n) begin
                    // Stop is held; only drop ready once a phase has completed.
                    if (phase_done) pins_nxt.rdy_n = 1'b1;
                end else if (pending) begin
                    pins_nxt = pins;
                end else if (be_fatal) begin
                    pins_nxt.sel_n = 1'b1;
                    pins_nxt.rdy_n = 1'b1;
                    pins_nxt.end_n = 1'b0;
                    abort_issue    = 1'b1;
                end else if (be_stop) begin
                    pins_nxt.end_n = 1'b0;
                    pins_nxt.rdy_n = ~be_ready;
                end else begin
                    pins_nxt.rdy_n = ~be_ready;
                end
            end
            ST_PARK: begin
                st_nxt   = ST_IDLE;
                pins_nxt = PINS_OFF;
            end
            default: begin
                st_nxt   = ST_IDLE;
                pins_nxt = PINS_OFF;
            end
        endcase
    end

    // State and drive registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            pins <= PINS_OFF;
        end else begin
            st   <= st_nxt;
            pins <= pins_nxt;
        end
    end

endmodule

// File: rtl/tgt_term_ctrl.sv
// Module: tgt_term_ctrl (top)
// Target-side claim, pacing and termination controller. Wires the phase
// monitor, the drive FSM, the transfer counter and the sticky abort flag.
// Assumes a separate decoder supplies addr_hit_i in the address phase.
module tgt_term_ctrl
    import tgt_term_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_n_i,
    input  logic             mrdy_n_i,
    input  logic             addr_hit_i,
    input  logic             be_ready_i,
    input  logic             be_stop_i,
    input  logic             be_fatal_i,
    output logic             sel_n_o,
    output logic             sel_oe_o,
    output logic             rdy_n_o,
    output logic             rdy_oe_o,
    output logic             end_n_o,
    output logic             end_oe_o,
    output logic             xfer_o,
    output logic [CNT_W-1:0] xfer_cnt_o,
    output logic             tabort_o
);

    pins_t pins;
    logic  idle, in_data, claim, abort_issue;
    logic  addr_phase, phase_done, last_done;

    tgt_phase_mon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_n      (cyc_n_i),
        .mrdy_n     (mrdy_n_i),
        .idle       (idle),
        .in_data    (in_data),
        .rdy_n      (pins.rdy_n),
        .end_n      (pins.end_n),
        .addr_phase (addr_phase),
        .phase_done (phase_done),
        .last_done  (last_done),
        .xfer       (xfer_o)
    );

    tgt_term_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_phase  (addr_phase),
        .addr_hit    (addr_hit_i),
        .phase_done  (phase_done),
        .last_done   (last_done),
        .be_ready    (be_ready_i),
        .be_stop     (be_stop_i),
        .be_fatal    (be_fatal_i),
        .pins        (pins),
        .idle        (idle),
        .in_data     (in_data),
        .claim       (claim),
        .abort_issue (abort_issue)
    );

    tgt_xfer_count #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (claim),
        .inc   (xfer_o),
        .count (xfer_cnt_o)
    );

    tgt_abort_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (abort_issue),
        .flag  (tabort_o)
    );

    // One shared enable; individual drive values from the FSM registers.
    assign sel_n_o  = pins.sel_n;
    assign rdy_n_o  = pins.rdy_n;
    assign end_n_o  = pins.end_n;
    assign sel_oe_o = pins.oe;
    assign rdy_oe_o = pins.oe;
    assign end_oe_o = pins.oe;

endmodule

// File: rtl/tgt_term_chk.sv
// Module: tgt_term_chk
// Protocol checker bound to tgt_term_ctrl. Assumes a master that follows
// the bus rules (framing raised no later than its final completing phase).
module tgt_term_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_n,
    input logic             mrdy_n,
    input logic             sel_n,
    input logic             sel_oe,
    input logic             rdy_n,
    input logic             rdy_oe,
    input logic             end_n,
    input logic             end_oe,
    input logic             xfer,
    input logic [CNT_W-1:0] xfer_cnt,
    input logic             tabort
);

    // R4: lines frozen while a phase is pending and the master is not ready.
    a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_oe && (!rdy_n || !end_n) && mrdy_n) |=> $stable({sel_n, rdy_n, end_n}));

    // R5: stop held until framing is released with a completing phase.
    a_r5_end_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (end_oe && !end_n && !(cyc_n && !mrdy_n)) |=> (end_oe && !end_n));

    // R10: park deasserted one clock, then release.
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_oe && cyc_n && !mrdy_n && (!rdy_n || !end_n))
        |=> (sel_oe && rdy_oe && end_oe && sel_n && rdy_n && end_n)
        ##1 (!sel_oe && !rdy_oe && !end_oe));

    // R8: during an abort the ready line is never asserted.
    a_r8_abort_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_oe && sel_n) |-> rdy_n);

    // R9: abort signalling implies the flag is set.
    a_r9_flag_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_oe && sel_n && !end_n) |-> tabort);

    // R9: the flag is sticky.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tabort |=> tabort);

    // R3: every transfer steps the count by one.
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (xfer_cnt == $past(xfer_cnt) + CNT_W'(1)));

endmodule

bind tgt_term_ctrl tgt_term_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_n    (cyc_n_i),
    .mrdy_n   (mrdy_n_i),
    .sel_n    (sel_n_o),
    .sel_oe   (sel_oe_o),
    .rdy_n    (rdy_n_o),
    .rdy_oe   (rdy_oe_o),
    .end_n    (end_n_o),
    .end_oe   (end_oe_o),
    .xfer     (xfer_o),
    .xfer_cnt (xfer_cnt_o),
    .tabort   (tabort_o)
);

// File: tb/tb_tgt_term_ctrl.sv
// Bench: sweeps normal bursts over beat count, backend wait and master wait,
// then retry, disconnect and abort variants, with a bus-rule master model.
module tb_tgt_term_ctrl;

    localparam int CLK_P = 10;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_n = 1'b1, mrdy_n = 1'b1, hit = 1'b0;
    logic bready = 1'b0, bstop = 1'b0, bfatal = 1'b0;
    logic sel_n, sel_oe, rdy_n, rdy_oe, end_n, end_oe, xfer, tabort;
    logic [CNT_W-1:0] xcnt;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tgt_term_ctrl #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_n_i(cyc_n), .mrdy_n_i(mrdy_n),
        .addr_hit_i(hit), .be_ready_i(bready), .be_stop_i(bstop), .be_fatal_i(bfatal),
        .sel_n_o(sel_n), .sel_oe_o(sel_oe), .rdy_n_o(rdy_n), .rdy_oe_o(rdy_oe),
        .end_n_o(end_n), .end_oe_o(end_oe), .xfer_o(xfer), .xfer_cnt_o(xcnt),
        .tabort_o(tabort)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare {sel_n,rdy_n,end_n,oe,oe,oe} as one 6-bit value.
    task automatic chk_pins(input string req, input bit s, input bit r, input bit e, input bit o);
        chk(req, int'({sel_n, rdy_n, end_n, sel_oe, rdy_oe, end_oe}), int'({s, r, e, o, o, o}));
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic claim(input bit h);
        cyc_n = 1'b0; hit = h;
        tick();
        hit = 1'b0;
        if (h) chk_pins("R2 claim", 0, 1, 1, 1);
        else   chk_pins("R2 no claim", 1, 1, 1, 0);
    endtask

    task automatic finish_release(input string req);
        chk_pins(req, 1, 1, 1, 1);
        mrdy_n = 1'b1; cyc_n = 1'b1;
        tick();
        chk_pins("R10 release", 1, 1, 1, 0);
    endtask

    task automatic normal(input int nb, input int bw, input int iw);
        claim(1'b1);
        chk("R3 count cleared", int'(xcnt), 0);
        for (int b = 0; b < nb; b++) begin
            repeat (bw) begin
                bready = 1'b0; tick();
                chk("R3 not ready", int'(rdy_n), 1);
            end
            bready = 1'b1; tick();
            chk_pins("R3 ready", 0, 0, 1, 1);
            bready = 1'b0; bstop = 1'b1; bfatal = 1'b1;
            repeat (iw) begin
                tick();
                chk_pins("R4 frozen", 0, 0, 1, 1);
            end
            bstop = 1'b0; bfatal = 1'b0;
            mrdy_n = 1'b0; cyc_n = (b == nb - 1);
            #1 chk("R3 xfer", int'(xfer), 1);
            tick();
            if (b == nb - 1) finish_release("R10 park after last");
            else begin
                chk("R3 new phase", int'(rdy_n), 1);
                mrdy_n = 1'b1;
            end
        end
        chk("R3 count", int'(xcnt), nb);
        tick();
    endtask

    task automatic retry(input bit lag);
        claim(1'b1);
        bstop = 1'b1; bready = 1'b0;
        tick();
        chk_pins("R6 retry", 0, 1, 0, 1);
        bstop = 1'b0;
        repeat (2) begin
            tick();
            chk_pins("R5 hold", 0, 1, 0, 1);
        end
        mrdy_n = 1'b0; cyc_n = !lag;
        #1 chk("R6 no xfer", int'(xfer), 0);
        tick();
        if (lag) begin
            chk_pins("R5 hold while framing", 0, 1, 0, 1);
            cyc_n = 1'b1;
            tick();
        end
        finish_release("R10 park after retry");
        chk("R6 count zero", int'(xcnt), 0);
        tick();
    endtask

    task automatic pre_beats(input int pre);
        for (int p = 0; p < pre; p++) begin
            bready = 1'b1; tick();
            chk("R3 pre ready", int'(rdy_n), 0);
            mrdy_n = 1'b0; bready = 1'b0; tick();
            chk("R3 pre done", int'(rdy_n), 1);
            mrdy_n = 1'b1;
        end
    endtask

    task automatic disc(input int pre, input bit lag);
        claim(1'b1);
        pre_beats(pre);
        bstop = 1'b1; bready = 1'b1;
        tick();
        chk_pins("R7 disconnect", 0, 0, 0, 1);
        bstop = 1'b0; bready = 1'b0;
        mrdy_n = 1'b0; cyc_n = !lag;
        #1 chk("R3 xfer with stop", int'(xfer), 1);
        tick();
        if (lag) begin
            chk_pins("R7 ready off stop held", 0, 1, 0, 1);
            chk("R7 no second xfer", int'(xfer), 0);
            cyc_n = 1'b1;
            tick();
        end
        finish_release("R10 park after disconnect");
        chk("R3 count disconnect", int'(xcnt), pre + 1);
        chk("R9 no flag on disconnect", int'(tabort), 0);
        tick();
    endtask

    task automatic abort_t(input int pre);
        claim(1'b1);
        pre_beats(pre);
        bfatal = 1'b1; bstop = 1'b1; bready = 1'b1;
        tick();
        chk_pins("R8 abort", 1, 1, 0, 1);
        chk("R9 flag set", int'(tabort), 1);
        bfatal = 1'b0; bstop = 1'b0; bready = 1'b0;
        mrdy_n = 1'b0; cyc_n = 1'b1;
        #1 chk("R8 no xfer", int'(xfer), 0);
        tick();
        finish_release("R10 park after abort");
        chk("R8 count", int'(xcnt), pre);
        tick();
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk_pins("R1 reset", 1, 1, 1, 0);
        chk("R1 flag", int'(tabort), 0);
        chk("R1 count", int'(xcnt), 0);
        rst_n = 1'b1;
        tick();

        // R2: miss, then a hit asserted mid-access is ignored.
        claim(1'b0);
        hit = 1'b1; tick();
        chk_pins("R2 hit outside address phase", 1, 1, 1, 0);
        hit = 1'b0; cyc_n = 1'b1; tick();

        for (int nb = 1; nb <= 3; nb++)
            for (int bw = 0; bw <= 2; bw++)
                for (int iw = 0; iw <= 2; iw++)
                    normal(nb, bw, iw);

        for (int lag = 0; lag <= 1; lag++) retry(lag[0]);
        chk("R9 no flag on retry", int'(tabort), 0);
        for (int pre = 0; pre <= 1; pre++)
            for (int lag = 0; lag <= 1; lag++)
                disc(pre, lag[0]);
        for (int pre = 0; pre <= 1; pre++) abort_t(pre);
        normal(2, 1, 1);
        chk("R9 flag sticky", int'(tabort), 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule